// File: doc/BRIEF.md
# Dual-Mode Display Controller Host Port

This block is the host-facing front end of a display controller. A microprocessor reaches the controller through one shared set of pins, and those pins take one of three forms. The first is an 8-bit parallel bus with an enable strobe and a read/not-write line. The second is an 8-bit parallel bus with separate active-low read and write strobes. The third is a write-only serial link that uses two of the data pins as data and clock. Two static straps choose the form. The mode strap picks parallel or serial. In parallel mode, the bus strap picks the enable-strobe style (1) or the split-strobe style (0).

All host pins pass through two-flop synchronizers into the internal clock domain before they are decoded. Each completed access becomes a one-cycle pulse on `xact_valid` with a two-bit kind and a data byte. During a parallel read, the block drives the data-bus output enable and returns either a display byte or a status byte, which come in on plain input ports. The tri-state buffer itself lives outside the block and is formed from `d_out` and `d_oe`.

Top module: `lcd_host_port`

## Requirements
- R1: In split-strobe parallel mode (mode strap 1, bus strap 0), taking `wr_rw` low and then high while selected produces exactly one transaction. It is issued only after the strobe returns high, and it carries the byte that was on `d_in` while the strobe was low.
- R2: In split-strobe parallel mode, holding `rd_e` low while selected sets `d_oe` to 1 and drives `d_out` with `disp_rdata` when A0=1 or with `stat_rdata` when A0=0. One read transaction is issued on the leading edge of the strobe, carrying that byte. `d_oe` returns to 0 after the strobe is released.
- R3: In enable-strobe parallel mode (bus strap 1), `rd_e` is the enable E and `wr_rw` is read/not-write. E high with R/W=0 followed by E low issues a write. E high with R/W=1 asserts `d_oe` and issues a read. E low never asserts `d_oe`.
- R4: `xact_kind` is {A0, is_read}: 0 = command write, 1 = status read, 2 = display data write, 3 = display data read.
- R5: An access counts only while `cs1_n`=0 and `cs2`=1. With either select inactive, strobes produce no transaction and `d_oe` stays 0.
- R6: In serial mode (mode strap 0), `d_in[7]` is serial data and `d_in[6]` is serial clock. Bits are shifted in MSB first on rising clock edges. On the eighth bit, one write transaction is issued, whose kind is 2 if A0=1 or 0 if A0=0.
- R7: In serial mode no read is possible. `d_oe` stays 0, and toggling `rd_e`, `wr_rw` or the bus strap produces no transaction.
- R8: In serial mode, deselecting the chip discards a partial byte and restarts the bit count. The next eight clocked bits form the byte.
- R9: During reset and right after it, `xact_valid` and `d_oe` are 0.
- R10: If a write strobe ends in the same cycle as the chip is deselected, exactly one write transaction is still issued, carrying the data held during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_par | input | 1 | Strap: 1 parallel, 0 serial |
| bus_e_style | input | 1 | Strap: 1 enable-strobe bus, 0 split-strobe bus |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| a0 | input | 1 | Register select: 1 display data, 0 command/status |
| rd_e | input | 1 | Read strobe (active low) or enable E |
| wr_rw | input | 1 | Write strobe (active low) or read/not-write |
| d_in | input | 8 | Data pins as seen by the block; serial data on bit 7, serial clock on bit 6 |
| d_out | output | 8 | Read data toward the data pins |
| d_oe | output | 1 | Output enable for the data pins |
| disp_rdata | input | 8 | Display byte returned on display reads |
| stat_rdata | input | 8 | Status byte returned on status reads |
| xact_valid | output | 1 | One-cycle pulse per decoded access |
| xact_kind | output | 2 | Access kind, see R4 |
| xact_data | output | 8 | Write data or returned read data |

## Verification
Two functions can fall in the same cycle: a write strobe completing and the chip deselecting. The bench provokes this by raising `wr_rw` and `cs1_n` in the same instant, so that both changes cross the synchronizers together. It then requires exactly one write pulse, carrying the byte held during the strobe. A second collision is a serial deselect that arrives mid-byte. The bench judges it by sending a full byte after reselecting and comparing the result with that byte alone.

// File: rtl/hif_pkg.sv
package hif_pkg;

    typedef enum logic [1:0] {
        XK_CMD_WR  = 2'b00,
        XK_STAT_RD = 2'b01,
        XK_DISP_WR = 2'b10,
        XK_DISP_RD = 2'b11
    } xact_kind_e;

    localparam int unsigned HIF_DW = 8;

    typedef struct packed {
        logic              valid;
        xact_kind_e        kind;
        logic [HIF_DW-1:0] data;
    } xact_t;

endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int unsigned         W       = 8,
    parameter int unsigned         STAGES  = 2,
    parameter logic [W-1:0]        RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hif_par_decode.sv
module hif_par_decode
    import hif_pkg::*;
#(
    parameter int unsigned DW = HIF_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sel,
    input  logic          e_style,
    input  logic          a0,
    input  logic          strb_a,
    input  logic          strb_b,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] disp_rdata,
    input  logic [DW-1:0] stat_rdata,
    output xact_t         xact,
    output logic          oe,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic          rd_act;
        logic          wr_act;
        logic          a0_hold;
        logic [DW-1:0] dat_hold;
        xact_t         xact;
    } par_st_t;

    par_st_t st_d, st_q;
    logic    rd_now, wr_now;
    logic [DW-1:0] rsel;

    always_comb begin
        if (e_style) begin
            rd_now = en & sel & strb_a & strb_b;
            wr_now = en & sel & strb_a & ~strb_b;
        end else begin
            rd_now = en & sel & ~strb_a;
            wr_now = en & sel & ~strb_b;
        end
        rsel = a0 ? disp_rdata : stat_rdata;

        st_d            = st_q;
        st_d.xact.valid = 1'b0;
        st_d.rd_act     = rd_now;
        st_d.wr_act     = wr_now;
        if (wr_now) begin
            st_d.a0_hold  = a0;
            st_d.dat_hold = din;
        end
        if (rd_now && !st_q.rd_act) begin
            st_d.xact.valid = 1'b1;
            st_d.xact.kind  = xact_kind_e'({a0, 1'b1});
            st_d.xact.data  = rsel;
        end else if (!wr_now && st_q.wr_act) begin
            st_d.xact.valid = 1'b1;
            st_d.xact.kind  = xact_kind_e'({st_q.a0_hold, 1'b0});
            st_d.xact.data  = st_q.dat_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xact = st_q.xact;
    assign oe   = rd_now;
    assign dout = rsel;
endmodule

// File: rtl/hif_ser_shift.sv
module hif_ser_shift
    import hif_pkg::*;
#(
    parameter int unsigned DW = HIF_DW
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  sel,
    input  logic  a0,
    input  logic  sclk,
    input  logic  sdat,
    output xact_t xact
);
    localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    typedef struct packed {
        logic          sclk_prev;
        logic [CW-1:0] cnt;
        logic [DW-1:0] shreg;
        xact_t         xact;
    } ser_st_t;

    ser_st_t       st_d, st_q;
    logic [DW-1:0] shifted;

    always_comb begin
        shifted         = {st_q.shreg[DW-2:0], sdat};
        st_d            = st_q;
        st_d.xact.valid = 1'b0;
        st_d.sclk_prev  = sclk;
        if (!en || !sel) begin
            st_d.cnt = '0;
        end else if (sclk && !st_q.sclk_prev) begin
            st_d.shreg = shifted;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt        = '0;
                st_d.xact.valid = 1'b1;
                st_d.xact.kind  = xact_kind_e'({a0, 1'b0});
                st_d.xact.data  = shifted;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xact = st_q.xact;
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
    import hif_pkg::*;
#(
    parameter int unsigned DW          = HIF_DW,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_par,
    input  logic          bus_e_style,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          a0,
    input  logic          rd_e,
    input  logic          wr_rw,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe,
    input  logic [DW-1:0] disp_rdata,
    input  logic [DW-1:0] stat_rdata,
    output logic          xact_valid,
    output logic [1:0]    xact_kind,
    output logic [DW-1:0] xact_data
);
    localparam int unsigned SW = DW + 7;
    localparam logic [SW-1:0] SYNC_RST = {3'b001, 4'b0000, {DW{1'b0}}};

    logic [SW-1:0] raw_bus, syn_bus;
    logic          mode_par_s, e_style_s, cs1_n_s, cs2_s, a0_s, rd_e_s, wr_rw_s;
    logic [DW-1:0] d_s;
    logic          sel_s;
    logic          par_oe;
    xact_t         par_x, ser_x, out_x;

    assign raw_bus = {mode_par, bus_e_style, cs1_n, cs2, a0, rd_e, wr_rw, d_in};

    hif_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    assign {mode_par_s, e_style_s, cs1_n_s, cs2_s, a0_s, rd_e_s, wr_rw_s, d_s} = syn_bus;
    assign sel_s = ~cs1_n_s & cs2_s;

    hif_par_decode #(.DW(DW)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode_par_s),
        .sel       (sel_s),
        .e_style   (e_style_s),
        .a0        (a0_s),
        .strb_a    (rd_e_s),
        .strb_b    (wr_rw_s),
        .din       (d_s),
        .disp_rdata(disp_rdata),
        .stat_rdata(stat_rdata),
        .xact      (par_x),
        .oe        (par_oe),
        .dout      (d_out)
    );

    hif_ser_shift #(.DW(DW)) u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (~mode_par_s),
        .sel  (sel_s),
        .a0   (a0_s),
        .sclk (d_s[DW-2]),
        .sdat (d_s[DW-1]),
        .xact (ser_x)
    );

    assign out_x      = mode_par_s ? par_x : ser_x;
    assign xact_valid = out_x.valid;
    assign xact_kind  = out_x.kind;
    assign xact_data  = out_x.data;
    assign d_oe       = mode_par_s & par_oe;
endmodule

// File: rtl/lcd_host_port_chk.sv
module lcd_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_par_s,
    input logic       sel_s,
    input logic       d_oe,
    input logic       xact_valid,
    input logic [1:0] xact_kind
);
    // R5: the output enable only rises for a selected parallel access
    p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> (mode_par_s && sel_s));

    // R2: every read pulse follows a cycle with the bus driven
    p_read_after_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_valid && xact_kind[0]) |-> $past(d_oe));

    // R7: the serial path never produces a read
    p_serial_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_valid && !mode_par_s) |-> !xact_kind[0]);

    // R9: quiet outputs in the cycle after a reset edge
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!xact_valid && !d_oe));
endmodule

bind lcd_host_port lcd_host_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_par_s(mode_par_s),
    .sel_s     (sel_s),
    .d_oe      (d_oe),
    .xact_valid(xact_valid),
    .xact_kind (xact_kind)
);

// File: tb/lcd_host_port_test.sv
`timescale 1ns/1ps
module lcd_host_port_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_par = 1'b1, bus_e_style = 1'b0;
    logic       cs1_n = 1'b1, cs2 = 1'b0, a0 = 1'b0;
    logic       rd_e = 1'b1, wr_rw = 1'b1;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe;
    logic [7:0] disp_rdata = 8'h5A, stat_rdata = 8'hC3;
    logic       xact_valid;
    logic [1:0] xact_kind;
    logic [7:0] xact_data;

    int total = 0, bad = 0;
    int pulses = 0;
    logic [1:0] last_kind = 2'b00;
    logic [7:0] last_data = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_host_port uut (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .bus_e_style(bus_e_style),
        .cs1_n(cs1_n), .cs2(cs2), .a0(a0), .rd_e(rd_e), .wr_rw(wr_rw),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .disp_rdata(disp_rdata), .stat_rdata(stat_rdata),
        .xact_valid(xact_valid), .xact_kind(xact_kind), .xact_data(xact_data)
    );

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (xact_valid === 1'b1) begin
            pulses++;
            last_kind = xact_kind;
            last_data = xact_data;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select_on();
        cs1_n = 1'b0; cs2 = 1'b1;
    endtask

    task automatic select_off();
        cs1_n = 1'b1; cs2 = 1'b0;
    endtask

    task automatic t_reset();
        cyc(1);
        chk("R9 valid in reset", xact_valid, 0);
        chk("R9 oe in reset", d_oe, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R9 valid after reset", xact_valid, 0);
        chk("R9 oe after reset", d_oe, 0);
        cyc(4);
        chk("R9 no pulses", pulses, 0);
    endtask

    task automatic split_write(input logic a, input logic [7:0] v, input logic [1:0] k);
        mode_par = 1'b1; bus_e_style = 1'b0; select_on();
        a0 = a; d_in = v; pulses = 0;
        cyc(1);
        wr_rw = 1'b0;
        cyc(5);
        chk("R1 no pulse before trailing edge", pulses, 0);
        wr_rw = 1'b1;
        cyc(1);
        d_in = ~v;
        cyc(6);
        chk("R1 one write pulse", pulses, 1);
        chk("R4 write kind", last_kind, k);
        chk("R1 write data", last_data, v);
    endtask

    task automatic split_read(input logic a, input logic [1:0] k, input logic [7:0] v);
        mode_par = 1'b1; bus_e_style = 1'b0; select_on();
        a0 = a; pulses = 0;
        cyc(1);
        rd_e = 1'b0;
        cyc(5);
        chk("R2 oe during read", d_oe, 1);
        chk("R2 bus data", d_out, v);
        chk("R2 one read pulse", pulses, 1);
        chk("R4 read kind", last_kind, k);
        chk("R2 read pulse data", last_data, v);
        rd_e = 1'b1;
        cyc(5);
        chk("R2 oe released", d_oe, 0);
        chk("R2 still one pulse", pulses, 1);
    endtask

    task automatic t_e_style();
        mode_par = 1'b1; bus_e_style = 1'b1; select_on();
        rd_e = 1'b0; wr_rw = 1'b1; a0 = 1'b1; pulses = 0;
        cyc(5);
        chk("R3 E low no oe", d_oe, 0);
        chk("R3 E low no pulse", pulses, 0);
        wr_rw = 1'b0; d_in = 8'h3C;
        cyc(1);
        rd_e = 1'b1;
        cyc(5);
        chk("R3 E high write no pulse yet", pulses, 0);
        chk("R3 E high write no oe", d_oe, 0);
        rd_e = 1'b0;
        cyc(6);
        chk("R3 write pulse", pulses, 1);
        chk("R3 write kind", last_kind, 2);
        chk("R3 write data", last_data, 8'h3C);
        wr_rw = 1'b1; a0 = 1'b0; pulses = 0;
        cyc(1);
        rd_e = 1'b1;
        cyc(5);
        chk("R3 read oe", d_oe, 1);
        chk("R3 read data", d_out, 8'hC3);
        chk("R3 read kind", last_kind, 1);
        rd_e = 1'b0;
        cyc(5);
        chk("R3 read one pulse", pulses, 1);
        bus_e_style = 1'b0;
        cyc(4);
    endtask

    task automatic t_unselected();
        mode_par = 1'b1; bus_e_style = 1'b0; pulses = 0;
        cs1_n = 1'b1; cs2 = 1'b1;
        wr_rw = 1'b0; cyc(4); wr_rw = 1'b1; cyc(4);
        cs1_n = 1'b0; cs2 = 1'b0;
        rd_e = 1'b0; cyc(4);
        chk("R5 no oe unselected", d_oe, 0);
        rd_e = 1'b1; cyc(4);
        chk("R5 no pulses unselected", pulses, 0);
        select_off();
    endtask

    task automatic ser_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            d_in[7] = b[i]; d_in[6] = 1'b0;
            cyc(3);
            d_in[6] = 1'b1;
            cyc(3);
        end
        d_in[6] = 1'b0;
        cyc(4);
    endtask

    task automatic ser_byte(input logic a, input logic [7:0] b, input logic [1:0] k);
        mode_par = 1'b0; select_on(); a0 = a; pulses = 0;
        d_in = 8'h00;
        cyc(4);
        ser_bits(b, 7);
        chk("R6 no pulse after seven bits", pulses, 0);
        ser_bits({b[0], 7'h00}, 1);
        chk("R6 one serial pulse", pulses, 1);
        chk("R6 serial kind", last_kind, k);
        chk("R6 serial data", last_data, b);
    endtask

    task automatic t_serial_ignore();
        mode_par = 1'b0; select_on(); a0 = 1'b1; d_in = 8'h00; pulses = 0;
        cyc(4);
        for (int s = 0; s < 2; s++) begin
            bus_e_style = s[0];
            rd_e = 1'b0; wr_rw = 1'b1; cyc(4);
            chk("R7 no oe on serial read strobe", d_oe, 0);
            rd_e = 1'b1; wr_rw = 1'b0; cyc(4);
            wr_rw = 1'b1; cyc(4);
        end
        bus_e_style = 1'b0;
        chk("R7 no pulses from ignored pins", pulses, 0);
    endtask

    task automatic t_serial_restart();
        mode_par = 1'b0; select_on(); a0 = 1'b1; d_in = 8'h00; pulses = 0;
        cyc(4);
        ser_bits(8'hFF, 3);
        select_off(); cyc(4);
        select_on(); cyc(4);
        ser_bits(8'h96, 8);
        chk("R8 one pulse after restart", pulses, 1);
        chk("R8 byte after restart", last_data, 8'h96);
    endtask

    task automatic t_collide();
        mode_par = 1'b1; bus_e_style = 1'b0; select_on();
        a0 = 1'b1; d_in = 8'hE7; pulses = 0;
        cyc(2);
        wr_rw = 1'b0; cyc(4);
        wr_rw = 1'b1; cs1_n = 1'b1;
        cyc(1);
        d_in = 8'h00;
        cyc(6);
        chk("R10 one pulse on collision", pulses, 1);
        chk("R10 kind on collision", last_kind, 2);
        chk("R10 data on collision", last_data, 8'hE7);
        cs2 = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        split_write(1'b0, 8'hA5, 2'd0);
        split_write(1'b1, 8'h3C, 2'd2);
        split_read(1'b1, 2'd3, 8'h5A);
        split_read(1'b0, 2'd1, 8'hC3);
        t_e_style();
        t_unselected();
        ser_byte(1'b1, 8'hB2, 2'd2);
        ser_byte(1'b0, 8'h4D, 2'd0);
        t_serial_ignore();
        t_serial_restart();
        t_collide();
        cyc(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule